// File: doc/BRIEF.md
# I2C Receive Data Match Unit

This block sits beside the receive path of an I2C master. It watches each data byte as it is received and sets a sticky match flag when a configured pattern shows up. A 3-bit mode input selects one of eight behaviours:

- disabled;
- a single-word compare against either of two match values, on the first word only or on any word;
- a two-word sequence, either the first and second words after a START or any two adjacent words;
- a masked compare, on the first word only or on any word.

Address bytes are never presented to the block. A start marker tells it that a START or repeated START has occurred, so that the next data byte counts as the first word of the transfer. Software clears the flag with a write-1-to-clear strobe.

Internally, a small sequence machine follows the position within the transfer. Its three states are:

- `SQ_FIRST`: the next word is the first one after a START.
- `SQ_ARMED`: the previous word equalled the first match value, and the mode allows a pair to complete.
- `SQ_OTHER`: any later position, with nothing pending.

The machine moves as follows:

- A start marker with no byte moves it to `SQ_FIRST`.
- A byte equal to the first match value moves it to `SQ_ARMED` in mode 5, and also in mode 4 when that byte is the first word.
- Every other byte moves it to `SQ_OTHER`.

An output process decodes the hit from the mode, the state and the compare results.

Top module: `i2c_rx_match`

## Requirements
- R1: After reset the match flag is 0, and the first byte received counts as the first word of a transfer.
- R2: Mode values 0 and 1 never set the flag, whatever data arrives.
- R3: Mode 2 sets the flag when the first data word after a START equals `match_a_i` or `match_b_i`. A later word that matches has no effect.
- R4: Mode 3 sets the flag when any data word equals `match_a_i` or `match_b_i`.
- R5: Mode 4 sets the flag only when the first word equals `match_a_i` and the second word equals `match_b_i`. The same pair appearing later in the transfer has no effect.
- R6: Mode 5 sets the flag when any word equals `match_a_i` and the word directly after it equals `match_b_i`. A pair separated by another word has no effect.
- R7: Mode 6 sets the flag when (first word AND `match_b_i`) equals (`match_a_i` AND `match_b_i`), so `match_b_i` acts as a bit mask. A later word that matches has no effect.
- R8: Mode 7 applies the masked compare of R7 to every data word.
- R9: A pulse on `start_i` makes the next byte the first word and cancels a pending pair. A byte strobed in the same cycle as `start_i` is itself the first word.
- R10: The flag stays at 1 until `clr_i` is pulsed. If `clr_i` and a new hit occur in the same cycle, the flag stays at 1.
- R11: The flag changes only on the clock edge that samples a byte strobe (or a clear). It is still 0 before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Match mode select (0..7) |
| match_a_i | input | 8 | First match value |
| match_b_i | input | 8 | Second match value, or the mask in modes 6 and 7 |
| start_i | input | 1 | START or repeated START marker |
| byte_vld_i | input | 1 | Received data byte strobe |
| byte_i | input | 8 | Received data byte |
| clr_i | input | 1 | Write-1-to-clear strobe for the flag |
| match_flag_o | output | 1 | Sticky data-match flag |

## Verification
The bench places matching words in the second position for the first-word modes. A design that ignores transfer position would raise the flag there.

It sends the pair values with a foreign word between them, with the order swapped, and with a repeated START between them. A design that holds a stale pending state, or that matches the values in either order, would report a false hit.

It issues a clear in the same cycle as a fresh hit, which a design that lets the clear win would lose. It also issues a start in the same cycle as a byte, which a design that re-arms one cycle late would misclassify.

It checks the masked modes with words that differ from the match value only in masked-out bits. An unmasked or inverted-mask compare would reject these words.

// File: rtl/i2c_dm_pkg.sv
package i2c_dm_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        SQ_FIRST = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_OTHER = 2'd2
    } seq_state_t;

    typedef enum logic [MODE_W-1:0] {
        MD_OFF        = 3'd0,
        MD_RSVD       = 3'd1,
        MD_FIRST_EITH = 3'd2,
        MD_ANY_EITH   = 3'd3,
        MD_FIRST_PAIR = 3'd4,
        MD_ANY_PAIR   = 3'd5,
        MD_FIRST_MASK = 3'd6,
        MD_ANY_MASK   = 3'd7
    } dm_mode_t;

endpackage

// File: rtl/dm_word_cmp.sv
module dm_word_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] word_i,
    input  logic [DW-1:0] ref_a_i,
    input  logic [DW-1:0] ref_b_i,
    output logic          eq_a_o,
    output logic          eq_b_o,
    output logic          eq_mask_o
);
    // Exact compares against each match value.
    assign eq_a_o    = (word_i == ref_a_i);
    assign eq_b_o    = (word_i == ref_b_i);
    // Masked compare: ref_b selects which bits must agree with ref_a.
    assign eq_mask_o = ((word_i & ref_b_i) == (ref_a_i & ref_b_i));
endmodule

// File: rtl/dm_seq_fsm.sv
module dm_seq_fsm
    import i2c_dm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              start_i,
    input  logic              vld_i,
    input  logic              eq_a_i,
    input  logic              eq_b_i,
    input  logic              eq_mask_i,
    output logic              hit_o
);
    seq_state_t state_q, state_d;
    dm_mode_t   mode;
    logic       at_first;
    logic       armed;
    logic       may_arm;

    assign mode     = dm_mode_t'(mode_i);
    // A start in the same cycle makes the current byte the first word.
    assign at_first = start_i || (state_q == SQ_FIRST);
    // A start cancels any pending pair.
    assign armed    = (state_q == SQ_ARMED) && !start_i;
    assign may_arm  = (mode == MD_ANY_PAIR) || ((mode == MD_FIRST_PAIR) && at_first);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (vld_i) begin
            state_d = (eq_a_i && may_arm) ? SQ_ARMED : SQ_OTHER;
        end else if (start_i) begin
            state_d = SQ_FIRST;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_FIRST;
        else        state_q <= state_d;
    end

    // Output decode: hit for the byte presented this cycle.
    always_comb begin
        hit_o = 1'b0;
        if (vld_i) begin
            unique case (mode)
                MD_OFF, MD_RSVD: hit_o = 1'b0;
                MD_FIRST_EITH:   hit_o = at_first && (eq_a_i || eq_b_i);
                MD_ANY_EITH:     hit_o = eq_a_i || eq_b_i;
                MD_FIRST_PAIR:   hit_o = armed && eq_b_i;
                MD_ANY_PAIR:     hit_o = armed && eq_b_i;
                MD_FIRST_MASK:   hit_o = at_first && eq_mask_i;
                MD_ANY_MASK:     hit_o = eq_mask_i;
                default:         hit_o = 1'b0;
            endcase
        end
    end

    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !vld_i) |=> (state_q == SQ_FIRST)); // R9
    AST_ARM_NEEDS_MATCH_A: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !eq_a_i) |=> (state_q != SQ_ARMED)); // R6
    AST_NO_HIT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i < 3'd2) |-> !hit_o); // R2
endmodule

// File: rtl/dm_flag.sv
module dm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // Set has priority over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q); // R10
    AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q); // R10
endmodule

// File: rtl/i2c_rx_match.sv
module i2c_rx_match
    import i2c_dm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DW-1:0]     match_a_i,
    input  logic [DW-1:0]     match_b_i,
    input  logic              start_i,
    input  logic              byte_vld_i,
    input  logic [DW-1:0]     byte_i,
    input  logic              clr_i,
    output logic              match_flag_o
);
    logic eq_a, eq_b, eq_mask, hit;

    dm_word_cmp #(.DW(DW)) u_cmp (
        .word_i    (byte_i),
        .ref_a_i   (match_a_i),
        .ref_b_i   (match_b_i),
        .eq_a_o    (eq_a),
        .eq_b_o    (eq_b),
        .eq_mask_o (eq_mask)
    );

    dm_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .start_i   (start_i),
        .vld_i     (byte_vld_i),
        .eq_a_i    (eq_a),
        .eq_b_i    (eq_b),
        .eq_mask_i (eq_mask),
        .hit_o     (hit)
    );

    dm_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit),
        .clr_i  (clr_i),
        .flag_o (match_flag_o)
    );

    AST_OFF_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i < 3'd2) && !match_flag_o) |=> !match_flag_o); // R2
    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld_i && !match_flag_o) |=> !match_flag_o); // R11
endmodule

// File: tb/tb_i2c_rx_match.sv
module tb_i2c_rx_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [7:0] ma = 8'h5A;
    logic [7:0] mb = 8'h3C;
    logic       start = 1'b0;
    logic       vld = 1'b0;
    logic [7:0] data = 8'h00;
    logic       clr = 1'b0;
    logic       flag;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    i2c_rx_match dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .match_a_i(ma), .match_b_i(mb),
        .start_i(start), .byte_vld_i(vld), .byte_i(data), .clr_i(clr),
        .match_flag_o(flag)
    );

    task automatic chk(input logic exp, input string req);
        n_checks++;
        if (flag !== exp) begin
            n_fail++;
            $display("FAIL %s: match_flag_o=%b expected %b", req, flag, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); vld = 1'b1; data = b;
        @(negedge clk); vld = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wclr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic t_reset();
        chk(1'b0, "R1 reset");
        mode = 3'd2;
        send(8'h3C);
        chk(1'b1, "R1 first byte after reset is first word");
        wclr();
    endtask

    task automatic t_off();
        for (int m = 0; m < 2; m++) begin
            mode = m[2:0];
            restart(); send(8'h5A); send(8'h3C); send(8'h5A);
            chk(1'b0, "R2 disabled mode");
        end
    endtask

    task automatic t_first_either();
        mode = 3'd2;
        restart(); send(8'h11); send(8'h5A);
        chk(1'b0, "R3 second word ignored");
        restart(); send(8'h3C);
        chk(1'b1, "R3 first word equals match_b");
        wclr();
        chk(1'b0, "R10 clear");
    endtask

    task automatic t_any_either();
        mode = 3'd3;
        restart(); send(8'h11); send(8'h22);
        chk(1'b0, "R4 no match yet");
        send(8'h3C);
        chk(1'b1, "R4 third word matches");
        wclr();
    endtask

    task automatic t_first_pair();
        mode = 3'd4;
        restart(); send(8'h11); send(8'h5A); send(8'h3C);
        chk(1'b0, "R5 late pair ignored");
        restart(); send(8'h5A); send(8'h11);
        chk(1'b0, "R5 wrong second word");
        restart(); send(8'h3C); send(8'h5A);
        chk(1'b0, "R5 swapped order");
        restart(); send(8'h5A); send(8'h3C);
        chk(1'b1, "R5 first pair");
        wclr();
    endtask

    task automatic t_any_pair();
        mode = 3'd5;
        restart(); send(8'h5A); send(8'h11); send(8'h3C);
        chk(1'b0, "R6 separated pair");
        send(8'h5A); restart(); send(8'h3C);
        chk(1'b0, "R9 start cancels pending pair");
        restart(); send(8'h11); send(8'h5A); send(8'h3C);
        chk(1'b1, "R6 adjacent pair");
        wclr();
    endtask

    task automatic t_mask();
        ma = 8'hA5; mb = 8'hF0;
        mode = 3'd6;
        restart(); send(8'h57); send(8'hA0);
        chk(1'b0, "R7 masked match in second word ignored");
        restart(); send(8'hA7);
        chk(1'b1, "R7 masked first word");
        wclr();
        mode = 3'd7;
        restart(); send(8'h57);
        chk(1'b0, "R8 masked mismatch");
        send(8'hAF);
        chk(1'b1, "R8 masked any word");
        wclr();
        ma = 8'h5A; mb = 8'h3C;
    endtask

    task automatic t_sticky_and_timing();
        mode = 3'd3;
        restart();
        @(negedge clk); vld = 1'b1; data = 8'h5A;
        #1 chk(1'b0, "R11 flag not yet set before edge");
        @(negedge clk); vld = 1'b0;
        chk(1'b1, "R11 flag set after edge");
        send(8'h00); send(8'h77);
        chk(1'b1, "R10 flag sticky");
        @(negedge clk); vld = 1'b1; data = 8'h3C; clr = 1'b1;
        @(negedge clk); vld = 1'b0; clr = 1'b0;
        chk(1'b1, "R10 hit beats clear");
        wclr();
        chk(1'b0, "R10 clear alone");
        mode = 3'd2;
        send(8'h11);
        @(negedge clk); start = 1'b1; vld = 1'b1; data = 8'h5A;
        @(negedge clk); start = 1'b0; vld = 1'b0;
        chk(1'b1, "R9 start with byte is first word");
        wclr();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_first_either();
        t_any_either();
        t_first_pair();
        t_any_pair();
        t_mask();
        t_sticky_and_timing();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule